// File: doc/BRIEF.md
# Serial Converter Result Readout Port

This block is the digital side of the three-wire serial port of a 10-bit successive-approximation converter. It runs on a fast system clock and samples two host-driven lines: an active-low select and a serial clock. Both lines pass through synchronisers. The block counts the falling edges of the serial clock. It shifts the previous conversion result out most-significant bit first and produces the timing signals that the analog front end and the conversion sequencer need. These are a sample-window flag and a one-cycle start-conversion strobe.

A frame begins when an accepted falling edge of the select line captures the result word and drives its top bit straight away. Each later serial clock falling edge shows the next lower bit. After the last data edge the line is held low, so longer transfers read zeros. The host can raise the select line between transfers. It can also keep it low and send 16-clock frames back to back, in which case the sixteenth edge starts the next frame by itself. Changes on the select line count only after they have held for a set number of system clocks.

Top module: `adc_serial_port`

## Requirements
- R1: While the accepted select level is high, `sdo_oe` and `sdo` are 0, `sampling` is 0, and serial clock edges have no effect: after select falls, the first falling edge still shows bit DATA_W-2.
- R2: An accepted select falling edge captures `result`, sets `sdo_oe` to 1 and drives `result[DATA_W-1]` on `sdo` before any serial clock edge.
- R3: Falling edge k of the serial clock (1 ≤ k ≤ DATA_W-1) puts captured bit DATA_W-1-k on `sdo`, so the LSB (bit 0) appears on edge DATA_W-1 (the ninth when DATA_W is 10).
- R4: From falling edge DATA_W (the tenth) through edge 15, `sdo` is held at 0.
- R5: `sampling` rises on the third falling edge and falls on edge DATA_W, so it is 1 after edges 3 to DATA_W-1 and 0 otherwise.
- R6: `conv_start` is a pulse of exactly one system clock, given once per frame on falling edge DATA_W.
- R7: With select held low, the sixteenth falling edge captures `result` afresh, puts its MSB on `sdo` at once, and restarts the edge count, so the next edges shift out the new word as in R3. The edge count never exceeds 16.
- R8: A change of the synchronised select level that lasts fewer than HOLD_CYCLES system clocks is ignored: the frame in progress continues and `sdo_oe` stays 1.
- R9: Changes on `result` after a frame has captured it do not alter the bits shifted out in that frame.
- R10: After synchronous reset, `sdo_oe`, `sdo`, `sampling` and `conv_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Host select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| result | input | DATA_W | Latest conversion result from the sequencer |
| sdo | output | 1 | Serial data bit for the pad |
| sdo_oe | output | 1 | Pad output enable (0 = high impedance) |
| sampling | output | 1 | Sample window flag for the analog front end |
| conv_start | output | 1 | One-cycle strobe that hands control to the conversion sequencer |

## Verification
The bench builds the block with its defaults, DATA_W = 10 and a frame limit of 16 edges, and with HOLD_CYCLES lowered to 4. This keeps each select transition short, so one run can sweep many result words through every edge position from 1 to 16. It also reaches the glitch case: a 2-cycle select pulse falls below the hold threshold, while every normal transition exceeds it by a clear margin. Back-to-back 16-clock frames with select held low, and a result word that changes mid-frame, cover the reload and capture rules.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
    // Serial clock edges in one full frame; also the continuous-select frame length
    localparam int MAX_EDGES   = 16;
    localparam int EDGE_CNT_W  = $clog2(MAX_EDGES + 1);
    // Edge on which the sample window opens
    localparam int SAMPLE_OPEN = 3;

    typedef logic [EDGE_CNT_W-1:0] edge_cnt_t;

    typedef struct packed {
        edge_cnt_t edges;       // falling edges seen in this frame
        logic      forced_low;  // data line held low after the last data bit
        logic      sampling;    // sample window open
        logic      conv_start;  // one-cycle hand-off strobe
    } frame_state_t;

    localparam frame_state_t FRAME_IDLE = '{edges: '0, forced_low: 1'b0,
                                            sampling: 1'b0, conv_start: 1'b0};

    function automatic edge_cnt_t next_edge(input edge_cnt_t cur);
        return (cur >= edge_cnt_t'(MAX_EDGES)) ? cur : cur + edge_cnt_t'(1);
    endfunction
endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/adcsp_cs_filter.sv
module adcsp_cs_filter #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_sync,
    output logic selected
);
    localparam int HCNT_W = $clog2(HOLD_CYCLES + 1);

    logic              acc_n_q;
    logic [HCNT_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_n_q <= 1'b1;
            hold_q  <= '0;
        end else if (cs_n_sync == acc_n_q) begin
            hold_q  <= '0;
        end else if (hold_q == HCNT_W'(HOLD_CYCLES - 1)) begin
            acc_n_q <= cs_n_sync;
            hold_q  <= '0;
        end else begin
            hold_q  <= hold_q + HCNT_W'(1);
        end
    end

    assign selected = ~acc_n_q;

    // An accepted level must equal the synchronised level that was held
    AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_n_q) |-> ($past(cs_n_sync) == acc_n_q)); // R8
endmodule

// File: rtl/adcsp_frame.sv
module adcsp_frame
    import adcsp_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              selected,
    input  logic              sclk_fall,
    input  logic [DATA_W-1:0] result,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sampling,
    output logic              conv_start
);
    localparam edge_cnt_t LAST_DATA  = edge_cnt_t'(DATA_W - 1);
    localparam edge_cnt_t CLOSE_EDGE = edge_cnt_t'(DATA_W);

    frame_state_t      st_q;
    logic [DATA_W-1:0] shreg_q;
    logic              sel_q;
    logic              start;
    edge_cnt_t         n;

    assign start = selected & ~sel_q;
    assign n     = next_edge(st_q.edges);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= FRAME_IDLE;
            shreg_q <= '0;
            sel_q   <= 1'b0;
        end else begin
            sel_q           <= selected;
            st_q.conv_start <= 1'b0;
            if (!selected) begin
                st_q <= FRAME_IDLE;
            end else if (start) begin
                st_q    <= FRAME_IDLE;
                shreg_q <= result;
            end else if (sclk_fall && st_q.edges < edge_cnt_t'(MAX_EDGES)) begin
                st_q.edges <= n;
                if (n <= LAST_DATA)
                    shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                if (n == edge_cnt_t'(SAMPLE_OPEN))
                    st_q.sampling <= 1'b1;
                if (n == CLOSE_EDGE) begin
                    st_q.sampling   <= 1'b0;
                    st_q.forced_low <= 1'b1;
                    st_q.conv_start <= 1'b1;
                end
                if (n == edge_cnt_t'(MAX_EDGES)) begin
                    // continuous-select framing: next frame begins here
                    st_q.edges      <= '0;
                    st_q.forced_low <= 1'b0;
                    shreg_q         <= result;
                end
            end
        end
    end

    assign sdo_oe     = sel_q;
    assign sdo        = sel_q & ~st_q.forced_low & shreg_q[DATA_W-1];
    assign sampling   = st_q.sampling;
    assign conv_start = st_q.conv_start;

    AST_EDGE_BOUND:  assert property (@(posedge clk) disable iff (rst)
        st_q.edges <= edge_cnt_t'(MAX_EDGES)); // R7
    AST_CONV_PULSE:  assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R6
    AST_CONV_LOW:    assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (!sdo && !sampling)); // R4
    AST_SAMPLE_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(sampling) |-> (st_q.edges == edge_cnt_t'(SAMPLE_OPEN))); // R5
    AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> (!sdo && !sampling)); // R1
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
    parameter int DATA_W      = 10,
    parameter int HOLD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] result,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sampling,
    output logic              conv_start
);
    logic cs_n_s, sclk_s, sclk_prev_q, selected, sclk_fall;

    adcsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) cs_sync_i (
        .clk(clk), .rst(rst), .din(cs_n), .dout(cs_n_s));

    adcsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) sclk_sync_i (
        .clk(clk), .rst(rst), .din(sclk), .dout(sclk_s));

    always_ff @(posedge clk) begin
        if (rst) sclk_prev_q <= 1'b0;
        else     sclk_prev_q <= sclk_s;
    end

    assign sclk_fall = sclk_prev_q & ~sclk_s;

    adcsp_cs_filter #(.HOLD_CYCLES(HOLD_CYCLES)) cs_filt_i (
        .clk(clk), .rst(rst), .cs_n_sync(cs_n_s), .selected(selected));

    adcsp_frame #(.DATA_W(DATA_W)) frame_i (
        .clk(clk), .rst(rst), .selected(selected), .sclk_fall(sclk_fall),
        .result(result), .sdo(sdo), .sdo_oe(sdo_oe),
        .sampling(sampling), .conv_start(conv_start));
endmodule

// File: tb/adc_serial_port_tb_top.sv
module adc_serial_port_tb_top;
    localparam int DW   = 10;
    localparam int HOLD = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic [DW-1:0] result = '0;
    logic          sdo, sdo_oe, sampling, conv_start;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_serial_port #(.DATA_W(DW), .HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .result(result),
        .sdo(sdo), .sdo_oe(sdo_oe), .sampling(sampling), .conv_start(conv_start));

    always @(posedge clk) if (!rst && conv_start) pulses <= pulses + 1;

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sclk_edge;
        sclk = 1'b1; wait_cyc(8);
        sclk = 1'b0; wait_cyc(8);
    endtask

    // checks one full 16-edge frame of word w after its MSB is already shown
    task automatic run_frame(input logic [DW-1:0] w, input logic [DW-1:0] next_w,
                             input bit cont);
        for (int k = 1; k <= 16; k++) begin
            int p0;
            p0 = pulses;
            if (k == 5) result = ~w;          // R9: late change must not matter
            if (k == 15) result = next_w;
            sclk_edge();
            if (k <= DW - 1)
                check(sdo, w[DW-1-k], "R3 data bit");
            else if (k < 16)
                check(sdo, 0, "R4 forced low");
            check(sampling, (k >= 3 && k <= DW - 1) ? 1 : 0, "R5 sample window");
            check(pulses - p0, (k == DW) ? 1 : 0, "R6 conv strobe");
            if (k == 16 && cont)
                check(sdo, next_w[DW-1], "R7 reload msb");
        end
    endtask

    initial begin
        wait_cyc(4);
        check(sdo_oe, 0, "R10 oe reset");
        check(sdo, 0, "R10 sdo reset");
        check(sampling, 0, "R10 sampling reset");
        check(conv_start, 0, "R10 strobe reset");
        rst = 1'b0;
        wait_cyc(2);

        // R1: clocks while deselected are ignored
        result = 10'h2B5;
        for (int i = 0; i < 5; i++) sclk_edge();
        check(sdo_oe, 0, "R1 oe off");
        check(sdo, 0, "R1 sdo low");
        check(pulses, 0, "R1 no strobe");
        cs_n = 1'b0; wait_cyc(20);
        check(sdo_oe, 1, "R2 oe on");
        check(sdo, 1, "R2 msb");
        sclk_edge();
        check(sdo, 0, "R1 first edge shows bit 8");
        cs_n = 1'b1; wait_cyc(20);
        check(sampling, 0, "R1 sampling cleared");

        // sweep of words with select toggled between frames
        for (int i = 0; i < 12; i++) begin
            logic [DW-1:0] w;
            w = (i == 0) ? 10'h3FF : (i == 1) ? 10'h000 : (i == 2) ? 10'h200 :
                (i == 3) ? 10'h001 : DW'((i * 173 + 37) ^ (i << 5));
            result = w;
            cs_n = 1'b0; wait_cyc(20);
            check(sdo_oe, 1, "R2 oe on");
            check(sdo, w[DW-1], "R2 msb before edges");
            run_frame(w, w, 1'b0);
            cs_n = 1'b1; wait_cyc(20);
            check(sdo_oe, 0, "R1 oe off after frame");
        end

        // continuous select: back-to-back 16-clock frames
        result = 10'h1A6;
        cs_n = 1'b0; wait_cyc(20);
        check(sdo, 0, "R2 msb of 1A6");
        run_frame(10'h1A6, 10'h2D3, 1'b1);
        run_frame(10'h2D3, 10'h0F1, 1'b1);
        run_frame(10'h0F1, 10'h3C0, 1'b1);

        // R8: short select glitch ignored; frame for 3C0 continues
        for (int k = 1; k <= DW - 1; k++) begin
            sclk_edge();
            if (k == 4) begin
                cs_n = 1'b1; wait_cyc(2);
                cs_n = 1'b0; wait_cyc(10);
                check(sdo_oe, 1, "R8 oe held");
            end
            check(sdo, (10'h3C0 >> (DW - 1 - k)) & 1, "R8 bits continue");
        end
        cs_n = 1'b1; wait_cyc(20);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule